// File: doc/BRIEF.md
# Local Bus Slave Bridge

This block is a synchronous target on a 32-bit processor local bus. A master opens a transfer with a one-cycle start strobe. The start strobe carries the low-order address bits, a read/write select, a two-bit size code and a burst flag. The block checks that the access is legal. It then chooses the byte lanes and forwards each beat to a simple internal request/grant port. For each beat it answers the master with one of three responses: an acknowledge, a transfer-error acknowledge or a retry request.

Lane 0 is the most significant byte of the bus, as in big-endian numbering. Each lane carries its own odd parity bit. Parity on write data is checked for the enabled lanes. Parity for read data is generated for every lane. A burst moves four words, and the beat address wraps inside an aligned 16-byte block. The master may end a burst early by negating its continue signal.

Top module: `lbus_slave`

## Requirements
- R1: While reset is held, and after it is released, `ack_n_o`, `tea_n_o` and `retry_n_o` are high and `req_o` is low until a transfer starts.
- R2: For a legal single write, `req_o` is raised with `req_we_o`=1, `req_addr_o` equal to the word-aligned address (the two low bits are zero) and `req_wdata_o` equal to the bus data. The request is held until `gnt_i`. A normal grant gives `ack_n_o` low for exactly one clock, in the cycle after the grant.
- R3: When `rd_wr_i` is high the access is a read (`req_we_o`=0). The granted `rsp_rdata_i` appears on `rdata_o` while `ack_n_o` is low. In that same cycle, each `rpar_o[i]` makes the byte `rdata_o[8i+7:8i]` plus itself hold an odd number of ones.
- R4: Size codes are 01 for a byte, 10 for a half-word and 00 for a word. A byte at address offset k (k = addr[1:0]) uses data bits [31-8k:24-8k] and enable bit `req_be_o[3-k]`. A half-word at offset 0 enables 1100, at offset 2 it enables 0011, and a word enables 1111.
- R5: Size code 11, an access not aligned to its size, or a burst whose size is not a word gets one `tea_n_o` pulse and makes no internal request.
- R6: On a write, a parity bit `wpar_i[i]` that fails odd parity over `wdata_i[8i+7:8i]` on an enabled lane gives `tea_n_o` and no request. A parity error on a lane that is not enabled is ignored.
- R7: `burst_n_i` low at start selects a burst of up to four word beats. The word address steps by 4 and wraps within the aligned 16-byte block, and each beat is acknowledged on its own.
- R8: `more_n_i` is sampled in the cycle a beat is acknowledged. If it is high then, the burst ends after that beat. If it is low, the next beat follows, up to four beats in all.
- R9: A grant with `rsp_err_i` high gives one `tea_n_o` pulse instead of an acknowledge and ends the transaction, including any remaining burst beats.
- R10: A grant with `rsp_retry_i` high gives one `retry_n_o` pulse and ends the transaction. Retry takes priority over error.
- R11: At most one of `ack_n_o`, `tea_n_o` and `retry_n_o` is low in any cycle, and none is low for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_n_i | input | 1 | Active-low transfer start, one cycle |
| addr_i | input | ADDR_W | Low-order byte address |
| rd_wr_i | input | 1 | 1 read from slave, 0 write to slave |
| size_i | input | 2 | Transfer size code |
| burst_n_i | input | 1 | Low selects a burst transfer |
| more_n_i | input | 1 | Low requests a further burst beat |
| wdata_i | input | DATA_W | Write data from master |
| wpar_i | input | DATA_W/8 | Odd parity per write lane |
| ack_n_o | output | 1 | Active-low beat acknowledge |
| tea_n_o | output | 1 | Active-low transfer error |
| retry_n_o | output | 1 | Active-low retry request |
| rdata_o | output | DATA_W | Read data to master |
| rpar_o | output | DATA_W/8 | Odd parity per read lane |
| req_o | output | 1 | Internal request |
| req_we_o | output | 1 | Internal request is a write |
| req_addr_o | output | ADDR_W | Word-aligned internal address |
| req_be_o | output | DATA_W/8 | Internal byte enables |
| req_wdata_o | output | DATA_W | Internal write data |
| gnt_i | input | 1 | Internal grant, ends the request |
| rsp_err_i | input | 1 | Internal error, valid with grant |
| rsp_retry_i | input | 1 | Internal retry, valid with grant |
| rsp_rdata_i | input | DATA_W | Internal read data, valid with grant |

## Verification
Single reads and writes are run with every size and offset. Reading the words back shows whether the byte enables merged the right lanes and whether zero and three wait states change anything. Illegal sizes, misalignment and parity errors are each placed on enabled and disabled lanes. This separates decode rejection from parity rejection, and it confirms that no internal request escapes. Bursts start at offsets that force the address to wrap. They stop after one, two, three or four beats, and internal errors or retries are injected at a chosen beat, which shows where the beat counter and the termination logic cut the sequence short.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RESP = 2'd2
    } bus_st_e;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;

endpackage

// File: rtl/lbus_lane_decode.sv
module lbus_lane_decode
    import lbus_pkg::*;
#(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [1:0]       size_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             burst_i,
    output logic [LANES-1:0] be_o,
    output logic             bad_o
);

    logic [OFF_W:0] span;
    logic           size_bad;
    logic [OFF_W:0] off_x;
    logic [OFF_W:0] lim;
    logic           misaligned;
    logic           burst_bad;

    always_comb begin
        size_bad = 1'b0;
        case (size_i)
            SZ_BYTE: span = (OFF_W+1)'(1);
            SZ_HALF: span = (OFF_W+1)'(2);
            SZ_WORD: span = (OFF_W+1)'(LANES);
            default: begin
                span     = (OFF_W+1)'(1);
                size_bad = 1'b1;
            end
        endcase
    end

    assign off_x      = {1'b0, off_i};
    assign lim        = off_x + span;
    assign misaligned = |(off_x & (span - 1'b1));
    assign burst_bad  = burst_i && (size_i != SZ_WORD);
    assign bad_o      = size_bad | misaligned | burst_bad;

    // byte offset k maps to enable bit LANES-1-k (offset 0 is the top lane)
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [OFF_W:0] LANE_K = (OFF_W+1)'(k);
        assign be_o[LANES-1-k] = !bad_o && (LANE_K >= off_x) && (LANE_K < lim);
    end

endmodule

// File: rtl/lbus_odd_parity.sv
module lbus_odd_parity #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] data_i,
    output logic [LANES-1:0]   par_o
);

    for (genvar i = 0; i < LANES; i++) begin : g_par
        assign par_o[i] = ~(^data_i[8*i +: 8]);
    end

endmodule

// File: rtl/lbus_slave.sv
module lbus_slave
    import lbus_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 32,
    parameter int BURST_LEN = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_n_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  rd_wr_i,
    input  logic [1:0]            size_i,
    input  logic                  burst_n_i,
    input  logic                  more_n_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DATA_W/8-1:0]   wpar_i,
    output logic                  ack_n_o,
    output logic                  tea_n_o,
    output logic                  retry_n_o,
    output logic [DATA_W-1:0]     rdata_o,
    output logic [DATA_W/8-1:0]   rpar_o,
    output logic                  req_o,
    output logic                  req_we_o,
    output logic [ADDR_W-1:0]     req_addr_o,
    output logic [DATA_W/8-1:0]   req_be_o,
    output logic [DATA_W-1:0]     req_wdata_o,
    input  logic                  gnt_i,
    input  logic                  rsp_err_i,
    input  logic                  rsp_retry_i,
    input  logic [DATA_W-1:0]     rsp_rdata_i
);

    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);
    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam int WA_W   = ADDR_W - OFF_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    typedef struct packed {
        bus_st_e             st;
        logic [WA_W-1:0]     waddr;
        logic                rd;
        logic                burst;
        logic [LANES-1:0]    be;
        logic [BEAT_W-1:0]   beat;
        logic                last;
        logic                ack;
        logic                tea;
        logic                rty;
        logic [DATA_W-1:0]   rdata;
    } slv_state_t;

    slv_state_t st_d, st_q;

    logic [LANES-1:0] dec_be;
    logic             dec_bad;
    logic [LANES-1:0] wpar_exp;
    logic             wpar_bad;
    logic             req;

    lbus_lane_decode #(
        .LANES (LANES)
    ) u_decode (
        .size_i  (size_i),
        .off_i   (addr_i[OFF_W-1:0]),
        .burst_i (!burst_n_i),
        .be_o    (dec_be),
        .bad_o   (dec_bad)
    );

    lbus_odd_parity #(
        .LANES (LANES)
    ) u_wpar (
        .data_i (wdata_i),
        .par_o  (wpar_exp)
    );

    lbus_odd_parity #(
        .LANES (LANES)
    ) u_rpar (
        .data_i (st_q.rdata),
        .par_o  (rpar_o)
    );

    assign wpar_bad = |((wpar_exp ^ wpar_i) & st_q.be);

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        st_d.tea = 1'b0;
        st_d.rty = 1'b0;
        req      = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (!start_n_i) begin
                    st_d.waddr = addr_i[ADDR_W-1:OFF_W];
                    st_d.rd    = rd_wr_i;
                    st_d.burst = !burst_n_i;
                    st_d.be    = dec_be;
                    st_d.beat  = '0;
                    if (dec_bad) begin
                        st_d.tea  = 1'b1;
                        st_d.last = 1'b1;
                        st_d.st   = ST_RESP;
                    end else begin
                        st_d.last = 1'b0;
                        st_d.st   = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (!st_q.rd && wpar_bad) begin
                    st_d.tea  = 1'b1;
                    st_d.last = 1'b1;
                    st_d.st   = ST_RESP;
                end else begin
                    req = 1'b1;
                    if (gnt_i) begin
                        st_d.st = ST_RESP;
                        if (rsp_retry_i) begin
                            st_d.rty  = 1'b1;
                            st_d.last = 1'b1;
                        end else if (rsp_err_i) begin
                            st_d.tea  = 1'b1;
                            st_d.last = 1'b1;
                        end else begin
                            st_d.ack  = 1'b1;
                            st_d.last = !st_q.burst || (st_q.beat == LAST_BEAT);
                            if (st_q.rd) begin
                                st_d.rdata = rsp_rdata_i;
                            end
                        end
                    end
                end
            end
            ST_RESP: begin
                if (st_q.last || more_n_i) begin
                    st_d.st = ST_IDLE;
                end else begin
                    st_d.st                = ST_REQ;
                    st_d.beat              = st_q.beat + 1'b1;
                    st_d.waddr[BEAT_W-1:0] = st_q.waddr[BEAT_W-1:0] + 1'b1;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_n_o     = !st_q.ack;
    assign tea_n_o     = !st_q.tea;
    assign retry_n_o   = !st_q.rty;
    assign rdata_o     = st_q.rdata;
    assign req_o       = req;
    assign req_we_o    = !st_q.rd;
    assign req_addr_o  = {st_q.waddr, {OFF_W{1'b0}}};
    assign req_be_o    = st_q.be;
    assign req_wdata_o = wdata_i;

endmodule

// File: rtl/lbus_slave_chk.sv
module lbus_slave_chk #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ack_n_o,
    input logic              tea_n_o,
    input logic              retry_n_o,
    input logic              req_o,
    input logic              gnt_i,
    input logic              rsp_err_i,
    input logic              rsp_retry_i,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [LANES-1:0]  req_be_o
);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (ack_n_o && tea_n_o && retry_n_o));

    // R11
    one_response_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({!ack_n_o, !tea_n_o, !retry_n_o}) <= 1);

    // R11
    ack_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_n_o |=> ack_n_o);

    // R11
    tea_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tea_n_o |=> tea_n_o);

    // R11
    retry_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !retry_n_o |=> retry_n_o);

    // R2
    req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !gnt_i) |=> (req_o && $stable(req_addr_o) && $stable(req_be_o)));

    // R2
    ack_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && gnt_i && !rsp_err_i && !rsp_retry_i) |=> !ack_n_o);

    // R9
    tea_after_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && gnt_i && rsp_err_i && !rsp_retry_i) |=> !tea_n_o);

    // R10
    retry_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && gnt_i && rsp_retry_i) |=> !retry_n_o);

    // R4
    lanes_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o |-> (req_be_o != '0));

endmodule

bind lbus_slave lbus_slave_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_lbus_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_n_o     (ack_n_o),
    .tea_n_o     (tea_n_o),
    .retry_n_o   (retry_n_o),
    .req_o       (req_o),
    .gnt_i       (gnt_i),
    .rsp_err_i   (rsp_err_i),
    .rsp_retry_i (rsp_retry_i),
    .req_addr_o  (req_addr_o),
    .req_be_o    (req_be_o)
);

// File: tb/test_lbus_slave.sv
module test_lbus_slave;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 18;
    localparam int DATA_W     = 32;
    localparam int LANES      = 4;

    typedef struct {
        int          kind;   // 0 ack, 1 tea, 2 retry
        bit          is_rd;
        logic [31:0] data;
        string       tag;
    } rsp_t;

    typedef struct {
        logic [17:0] addr;
        logic [3:0]  be;
        bit          we;
        logic [31:0] wdata;
        string       tag;
    } req_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              start_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              rd_wr = 1'b0;
    logic [1:0]        size = 2'b00;
    logic              burst_n = 1'b1;
    logic              more_n = 1'b1;
    logic [DATA_W-1:0] wdata = '0;
    logic [LANES-1:0]  wpar = '0;
    logic              ack_n, tea_n, retry_n;
    logic [DATA_W-1:0] rdata;
    logic [LANES-1:0]  rpar;
    logic              req, req_we;
    logic [ADDR_W-1:0] req_addr;
    logic [LANES-1:0]  req_be;
    logic [DATA_W-1:0] req_wdata;
    logic              gnt, rsp_err, rsp_retry;
    logic [DATA_W-1:0] rsp_rdata;

    lbus_slave #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BURST_LEN (4)
    ) i_lbus_slave (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_n_i   (start_n),
        .addr_i      (addr),
        .rd_wr_i     (rd_wr),
        .size_i      (size),
        .burst_n_i   (burst_n),
        .more_n_i    (more_n),
        .wdata_i     (wdata),
        .wpar_i      (wpar),
        .ack_n_o     (ack_n),
        .tea_n_o     (tea_n),
        .retry_n_o   (retry_n),
        .rdata_o     (rdata),
        .rpar_o      (rpar),
        .req_o       (req),
        .req_we_o    (req_we),
        .req_addr_o  (req_addr),
        .req_be_o    (req_be),
        .req_wdata_o (req_wdata),
        .gnt_i       (gnt),
        .rsp_err_i   (rsp_err),
        .rsp_retry_i (rsp_retry),
        .rsp_rdata_i (rsp_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    rsp_t rsp_q[$];
    req_t req_q[$];
    logic [31:0] ref_mem [16];
    logic [31:0] mem [16];

    function automatic logic [31:0] pat(int i);
        return 32'hA5000000 + 32'(i) * 32'h00010203;
    endfunction

    function automatic logic [3:0] oddp(logic [31:0] d);
        logic [3:0] p;
        for (int l = 0; l < 4; l++) p[l] = ~(^d[8*l +: 8]);
        return p;
    endfunction

    function automatic logic [31:0] wd(logic [17:0] a, int b);
        return {8'hC3, 6'b0, a} ^ (32'(b) << 12) ^ 32'h00F0_0F00;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // internal memory model with programmable wait states and fault beats
    int gcount;
    int wcnt;
    int wait_cycles = 0;
    int err_at = -1;
    int rty_at = -1;

    assign gnt       = req && (wcnt >= wait_cycles);
    assign rsp_err   = (gcount == err_at);
    assign rsp_retry = (gcount == rty_at);
    assign rsp_rdata = mem[req_addr[5:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            gcount <= 0;
            wcnt   <= 0;
            for (int i = 0; i < 16; i++) mem[i] <= pat(i);
        end else if (req && gnt) begin
            gcount <= gcount + 1;
            wcnt   <= 0;
            if (req_we && !rsp_err && !rsp_retry) begin
                for (int l = 0; l < 4; l++)
                    if (req_be[l]) mem[req_addr[5:2]][8*l +: 8] <= req_wdata[8*l +: 8];
            end
        end else if (req) begin
            wcnt <= wcnt + 1;
        end
    end

    // monitor: pops expected responses and requests as they appear
    logic [2:0] pulse;
    logic [2:0] prev_pulse;
    rsp_t m_rsp;
    req_t m_req;
    int   act_kind;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_pulse = '0;
        end else begin
            pulse = {!retry_n, !tea_n, !ack_n};
            if (pulse != 3'b000) begin
                check($countones(pulse) == 1, "R11", "responses overlap", 32'(pulse), 32'h1);
                check(prev_pulse == 3'b000, "R11", "response longer than one clock", 32'(prev_pulse), 32'h0);
                if (rsp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected response", 32'(pulse), 32'h0);
                end else begin
                    m_rsp = rsp_q.pop_front();
                    act_kind = pulse[0] ? 0 : (pulse[1] ? 1 : 2);
                    check(act_kind == m_rsp.kind, m_rsp.tag, "response kind", 32'(act_kind), 32'(m_rsp.kind));
                    if (pulse[0] && m_rsp.is_rd) begin
                        check(rdata == m_rsp.data, m_rsp.tag, "read data", rdata, m_rsp.data);
                        check(rpar == oddp(m_rsp.data), "R3", "read parity", 32'(rpar), 32'(oddp(m_rsp.data)));
                    end
                end
            end
            if (req && gnt) begin
                if (req_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected internal request", 32'(req_addr), 32'h0);
                end else begin
                    m_req = req_q.pop_front();
                    check(req_addr == m_req.addr, m_req.tag, "request address", 32'(req_addr), 32'(m_req.addr));
                    check(req_be == m_req.be, m_req.tag, "byte enables", 32'(req_be), 32'(m_req.be));
                    check(req_we == m_req.we, m_req.tag, "write select", 32'(req_we), 32'(m_req.we));
                    if (m_req.we)
                        check(req_wdata == m_req.wdata, m_req.tag, "write data", req_wdata, m_req.wdata);
                end
            end
            prev_pulse = pulse;
        end
    end

    // driver: queues expectations, then runs the bus handshake
    task automatic xfer(input bit rd, input logic [17:0] a, input logic [1:0] sz,
                        input bit bur, input int nbeats, input int bad_lane,
                        input int err_beat, input int rty_beat, input string tag);
        int off, n, total, seen, guard;
        bit bad, done, more_pend;
        logic [3:0] be, pmask;
        logic [17:0] ba;
        rsp_t r;
        req_t q;
        off = int'(a[1:0]);
        n = (sz == 2'b01) ? 1 : ((sz == 2'b10) ? 2 : 4);
        bad = (sz == 2'b11) || ((off % n) != 0) || (bur && sz != 2'b00);
        be = '0;
        for (int k = 0; k < 4; k++) if (k >= off && k < off + n) be[3-k] = 1'b1;
        pmask = (bad_lane >= 0) ? 4'(1 << bad_lane) : 4'h0;
        total = 0;
        r.is_rd = rd; r.tag = tag; r.data = '0;
        if (bad || (!rd && bad_lane >= 0 && be[bad_lane])) begin
            r.kind = 1; rsp_q.push_back(r); total = 1;
        end else begin
            for (int b = 0; b < (bur ? nbeats : 1); b++) begin
                ba = bur ? {a[17:4], 2'(a[3:2] + 2'(b)), 2'b00} : {a[17:2], 2'b00};
                q.addr = ba; q.be = be; q.we = !rd; q.wdata = wd(a, b); q.tag = tag;
                req_q.push_back(q);
                total++;
                if (b == rty_beat) begin r.kind = 2; rsp_q.push_back(r); break; end
                if (b == err_beat) begin r.kind = 1; rsp_q.push_back(r); break; end
                r.kind = 0;
                r.data = ref_mem[ba[5:2]];
                rsp_q.push_back(r);
                if (!rd)
                    for (int l = 0; l < 4; l++)
                        if (be[l]) ref_mem[ba[5:2]][8*l +: 8] = wd(a, b) >> (8*l);
            end
        end
        err_at = (err_beat >= 0) ? gcount + err_beat : -1;
        rty_at = (rty_beat >= 0) ? gcount + rty_beat : -1;
        @(negedge clk);
        start_n = 1'b0; rd_wr = rd; addr = a; size = sz; burst_n = !bur;
        more_n  = (bur && nbeats > 1) ? 1'b0 : 1'b1;
        wdata   = wd(a, 0); wpar = oddp(wd(a, 0)) ^ pmask;
        @(negedge clk);
        start_n = 1'b1;
        seen = 0; done = 1'b0; guard = 0; more_pend = 1'b0;
        while (!done) begin
            if (more_pend) begin
                more_n = (bur && seen + 1 < nbeats) ? 1'b0 : 1'b1;
                more_pend = 1'b0;
            end
            if (!ack_n || !tea_n || !retry_n) begin
                seen++;
                if (!ack_n && seen < total) begin
                    wdata = wd(a, seen); wpar = oddp(wd(a, seen)) ^ pmask;
                    more_pend = 1'b1;
                end else begin
                    done = 1'b1;
                end
            end
            if (!done) begin
                guard++;
                if (guard > 60) begin
                    check(1'b0, tag, "transfer did not finish", 32'(seen), 32'(total));
                    done = 1'b1;
                end
                @(negedge clk);
            end
        end
        @(negedge clk);
        more_n = 1'b1; err_at = -1; rty_at = -1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R1 watchdog expired: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = pat(i);
        repeat (3) @(negedge clk);
        check(ack_n && tea_n && retry_n, "R1", "responses in reset", {29'b0, ack_n, tea_n, retry_n}, 32'h7);
        rst_n = 1'b1;
        @(negedge clk);
        check(ack_n && tea_n && retry_n && !req, "R1", "idle after reset",
              {28'b0, ack_n, tea_n, retry_n, req}, 32'hE);

        xfer(0, 18'h10, 2'b00, 0, 1, -1, -1, -1, "R2");
        xfer(1, 18'h10, 2'b00, 0, 1, -1, -1, -1, "R3");
        xfer(0, 18'h21, 2'b01, 0, 1, -1, -1, -1, "R4");
        xfer(0, 18'h23, 2'b01, 0, 1, -1, -1, -1, "R4");
        xfer(0, 18'h26, 2'b10, 0, 1, -1, -1, -1, "R4");
        xfer(1, 18'h20, 2'b00, 0, 1, -1, -1, -1, "R4");
        xfer(1, 18'h24, 2'b00, 0, 1, -1, -1, -1, "R4");
        wait_cycles = 3;
        xfer(0, 18'h14, 2'b00, 0, 1, -1, -1, -1, "R2");
        xfer(1, 18'h14, 2'b00, 0, 1, -1, -1, -1, "R2");
        wait_cycles = 0;
        xfer(0, 18'h30, 2'b11, 0, 1, -1, -1, -1, "R5");
        xfer(1, 18'h31, 2'b10, 0, 1, -1, -1, -1, "R5");
        xfer(0, 18'h30, 2'b01, 1, 4, -1, -1, -1, "R5");
        xfer(1, 18'h32, 2'b00, 0, 1, -1, -1, -1, "R5");
        xfer(0, 18'h18, 2'b00, 0, 1, 3, -1, -1, "R6");
        xfer(1, 18'h18, 2'b00, 0, 1, -1, -1, -1, "R6");
        xfer(0, 18'h18, 2'b01, 0, 1, 0, -1, -1, "R6");
        xfer(1, 18'h18, 2'b00, 0, 1, -1, -1, -1, "R6");
        xfer(0, 18'h28, 2'b00, 1, 4, -1, -1, -1, "R7");
        xfer(1, 18'h28, 2'b00, 1, 4, -1, -1, -1, "R7");
        xfer(1, 18'h2C, 2'b00, 1, 4, -1, -1, -1, "R7");
        xfer(1, 18'h08, 2'b00, 1, 2, -1, -1, -1, "R8");
        xfer(1, 18'h04, 2'b00, 1, 1, -1, -1, -1, "R8");
        xfer(0, 18'h34, 2'b00, 1, 3, -1, -1, -1, "R8");
        xfer(1, 18'h30, 2'b00, 1, 4, -1, -1, -1, "R8");
        xfer(1, 18'h00, 2'b00, 1, 4, -1, 2, -1, "R9");
        xfer(0, 18'h3C, 2'b00, 0, 1, -1, 0, -1, "R9");
        xfer(1, 18'h3C, 2'b00, 0, 1, -1, -1, -1, "R9");
        xfer(0, 18'h0C, 2'b00, 0, 1, -1, -1, 0, "R10");
        xfer(1, 18'h0C, 2'b00, 0, 1, -1, -1, -1, "R10");
        xfer(0, 18'h20, 2'b00, 1, 4, -1, -1, 1, "R10");
        xfer(1, 18'h20, 2'b00, 1, 4, -1, -1, -1, "R10");

        repeat (4) @(negedge clk);
        check(rsp_q.size() == 0, "R11", "responses still pending", 32'(rsp_q.size()), 32'h0);
        check(req_q.size() == 0, "R2", "requests still pending", 32'(req_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule